// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times a single external bus access made by a processor that currently owns the bus. When an access starts, the block loads a programmed minimum wait count. It holds the cycle open until that minimum has elapsed and until the active-low transfer-acknowledge input has been seen asserted. A slow external device can therefore stretch the cycle for as long as it needs by keeping the acknowledge high. Whichever limit is later sets the length of the cycle.

The acknowledge is taken either straight from the pin (synchronous mode) or through a two-stage synchronizer (asynchronous mode). The synchronizer adds two clocks of latency. The acknowledge is not consulted in these cases:
- the programmed count is zero;
- the access is flagged as DRAM type;
- the unit is not bus master;
- no access is in progress.

The state machine has three states:
- `ST_IDLE` waits for a request.
- `ST_WAIT` counts wait states and watches the acknowledge.
- `ST_DONE` is the single cycle in which the access completes.

Its transitions are:
- IDLE→WAIT: a request is accepted while master and the count is nonzero.
- IDLE→DONE: a request is accepted while master and the count is zero.
- WAIT→WAIT: the minimum is not yet met, or the acknowledge condition is not yet met.
- WAIT→DONE: both conditions are met.
- DONE→IDLE: always, one clock later.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset, `active_o` and `done_o` are both 0.
- R2: A request (`start_i`=1) is accepted at a rising edge only when the block is idle and `master_i`=1. `active_o` is 1 from the cycle after acceptance through the done cycle.
- R3: With a programmed count of 0, `done_o` is 1 in the cycle right after acceptance, whatever the acknowledge does.
- R4: With a programmed count N≥1 and the acknowledge already asserted (`ack_n_i`=0), `done_o` rises N cycles after the acceptance edge.
- R5: In synchronous mode (`async_mode_i`=0), if `ack_n_i` first goes to 0 after the d-th edge following acceptance, `done_o` rises max(N, d+1) cycles after the acceptance edge.
- R6: In asynchronous mode (`async_mode_i`=1), the acknowledge passes through a two-stage synchronizer. The completion latency of R5 then becomes max(N, d+3).
- R7: When `dram_i`=1 at acceptance, the acknowledge is not used and `done_o` rises exactly N cycles after acceptance.
- R8: `done_o` is high for exactly one cycle, and the block is idle (`active_o`=0) in the following cycle.
- R9: With `master_i`=0, requests and acknowledge activity produce no output activity. While idle, acknowledge activity alone produces no output activity.
- R10: A request raised while an access is in progress is ignored and does not alter that access's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access start request |
| dram_i | input | 1 | Access is DRAM type (acknowledge not used) |
| master_i | input | 1 | Unit currently owns the external bus |
| wait_cnt_i | input | WAIT_W | Programmed minimum wait-state count |
| async_mode_i | input | 1 | 1: acknowledge through synchronizer, 0: sampled directly |
| ack_n_i | input | 1 | Active-low transfer acknowledge |
| active_o | output | 1 | Access cycle in progress |
| done_o | output | 1 | One-cycle access completion pulse |

## Verification
Assertions check the following on every cycle:
- the done pulse is one cycle wide and is followed by idle;
- done is never seen without the cycle being active;
- a zero-count access completes at once;
- the wait state is never left before the minimum count is met;
- a DRAM access leaves as soon as its minimum is met.

Only the bench scenarios can show the actual latency figures, because these depend on when the acknowledge is driven relative to acceptance:
- the longer-of-two rule in both acknowledge modes;
- the two extra cycles added by the synchronizer;
- that ignored requests and acknowledges leave the outputs untouched.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } ewc_state_e;

endpackage

// File: rtl/ewc_ack_sync.sv
module ewc_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    input  logic async_i,
    output logic ack_seen_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= ack_n_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Active-low pin turned into an active-high "acknowledge seen"
    assign ack_seen_o = async_i ? ~chain_q[STAGES-1] : ~ack_n_i;

endmodule

// File: rtl/ewc_wait_cnt.sv
module ewc_wait_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    output logic          min_met_o
);

    logic [CW-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (run_i && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Minimum met during the last programmed wait cycle
    assign min_met_o = (rem_q <= CW'(1));

    assert_min_reached_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && rem_q > CW'(1)) |=> (rem_q == $past(rem_q) - 1'b1))
        else $error("wait counter did not step down");

endmodule

// File: rtl/ewc_fsm.sv
module ewc_fsm
    import ewc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic master_i,
    input  logic dram_i,
    input  logic zero_i,
    input  logic min_met_i,
    input  logic ack_seen_i,
    output logic load_o,
    output logic run_o,
    output logic active_o,
    output logic done_o
);

    ewc_state_e state_q, state_d;
    logic       dram_q;
    logic       accept;
    logic       ack_ok;

    assign accept = (state_q == ST_IDLE) && start_i && master_i;
    assign ack_ok = dram_q || (master_i && ack_seen_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dram_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) dram_q <= dram_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = zero_i ? ST_DONE : ST_WAIT;
            end
            ST_WAIT: begin
                if (min_met_i && ack_ok) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o   = accept;
        run_o    = (state_q == ST_WAIT);
        active_o = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !active_o))
        else $error("done pulse longer than one cycle");

    assert_done_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> active_o)
        else $error("done without active cycle");

    assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_i) |=> done_o)
        else $error("zero-wait access did not complete at once");

    assert_min_before_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !min_met_i) |=> (state_q == ST_WAIT))
        else $error("wait left before minimum count");

    assert_dram_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && dram_q && min_met_i) |=> done_o)
        else $error("DRAM access waited on acknowledge");

    assert_no_master_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !master_i) |=> !active_o)
        else $error("access started without mastership");

endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl #(
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dram_i,
    input  logic              master_i,
    input  logic [WAIT_W-1:0] wait_cnt_i,
    input  logic              async_mode_i,
    input  logic              ack_n_i,
    output logic              active_o,
    output logic              done_o
);

    logic ack_seen;
    logic min_met;
    logic load;
    logic run;
    logic zero;

    assign zero = (wait_cnt_i == '0);

    ewc_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n_i    (ack_n_i),
        .async_i    (async_mode_i),
        .ack_seen_o (ack_seen)
    );

    ewc_wait_cnt #(.CW(WAIT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (wait_cnt_i),
        .run_i      (run),
        .min_met_o  (min_met)
    );

    ewc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .master_i   (master_i),
        .dram_i     (dram_i),
        .zero_i     (zero),
        .min_met_i  (min_met),
        .ack_seen_i (ack_seen),
        .load_o     (load),
        .run_o      (run),
        .active_o   (active_o),
        .done_o     (done_o)
    );

endmodule

// File: tb/ext_wait_ctrl_tb.sv
module ext_wait_ctrl_tb;

    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              dram_i = 1'b0;
    logic              master_i = 1'b1;
    logic [WAIT_W-1:0] wait_cnt_i = '0;
    logic              async_mode_i = 1'b0;
    logic              ack_n_i = 1'b1;
    logic              active_o;
    logic              done_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ext_wait_ctrl #(.WAIT_W(WAIT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dram_i       (dram_i),
        .master_i     (master_i),
        .wait_cnt_i   (wait_cnt_i),
        .async_mode_i (async_mode_i),
        .ack_n_i      (ack_n_i),
        .active_o     (active_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // d < 0: acknowledge asserted well before the request
    // d >= 0: acknowledge lowered at the negedge after the d-th edge past acceptance
    task automatic run_access(input string req, input int n, input bit dram,
                              input bit async_m, input int d, input bit mid_start);
        int exp_l;
        int lat;
        bit ok_act;
        async_mode_i = async_m;
        dram_i       = dram;
        wait_cnt_i   = WAIT_W'(n);
        if (d < 0) begin
            ack_n_i = 1'b0;
            repeat (4) @(negedge clk);
        end
        if (n == 0)       exp_l = 0;
        else if (dram)    exp_l = n;
        else if (d < 0)   exp_l = n;
        else              exp_l = (n > d + 1 + (async_m ? 2 : 0)) ? n : d + 1 + (async_m ? 2 : 0);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat    = -1;
        ok_act = 1'b1;
        for (int k = 0; k < 60; k++) begin
            if (done_o) begin
                lat = k;
                break;
            end
            if (!active_o) ok_act = 1'b0;
            if (k == d) ack_n_i = 1'b0;
            start_i = (mid_start && k == 1);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(ok_act, {req, " active during access (R2)"}, ok_act, 1);
        chk(lat == exp_l, {req, " latency"}, lat, exp_l);
        @(negedge clk);
        chk(!done_o && !active_o, {req, " idle after done (R8)"}, {30'd0, active_o, done_o}, 0);
        ack_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(!active_o, {req, " no restart (R10)"}, active_o, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!active_o && !done_o, "R1 reset outputs", {30'd0, active_o, done_o}, 0);
    endtask

    task automatic test_ignore();
        bit seen = 1'b0;
        master_i   = 1'b0;
        wait_cnt_i = WAIT_W'(2);
        for (int k = 0; k < 8; k++) begin
            start_i = k[0];
            ack_n_i = k[1];
            @(negedge clk);
            if (active_o || done_o) seen = 1'b1;
        end
        start_i  = 1'b0;
        ack_n_i  = 1'b1;
        master_i = 1'b1;
        chk(!seen, "R9 not master: no activity", seen, 0);
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            ack_n_i = k[0];
            @(negedge clk);
            if (active_o || done_o) seen = 1'b1;
        end
        ack_n_i = 1'b1;
        chk(!seen, "R9 idle ack: no activity", seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        run_access("R3 zero wait, ack high", 0, 1'b0, 1'b0, 50, 1'b0);
        run_access("R3 zero wait async", 0, 1'b0, 1'b1, 50, 1'b0);
        run_access("R4 min 1 ack ready", 1, 1'b0, 1'b0, -1, 1'b0);
        run_access("R4 min 5 ack ready", 5, 1'b0, 1'b0, -1, 1'b0);
        run_access("R5 sync late ack", 2, 1'b0, 1'b0, 6, 1'b0);
        run_access("R5 sync ack before min", 6, 1'b0, 1'b0, 2, 1'b0);
        run_access("R5 sync ack at once", 1, 1'b0, 1'b0, 0, 1'b0);
        run_access("R6 async late ack", 2, 1'b0, 1'b1, 4, 1'b0);
        run_access("R6 async ack hidden by min", 9, 1'b0, 1'b1, 1, 1'b0);
        run_access("R6 async ack ready", 3, 1'b0, 1'b1, -1, 1'b0);
        run_access("R7 dram ignores ack", 3, 1'b1, 1'b0, 50, 1'b0);
        run_access("R7 dram async", 15, 1'b1, 1'b1, 50, 1'b0);
        run_access("R10 start mid access", 4, 1'b0, 1'b0, 5, 1'b1);
        test_ignore();
        run_access("R8 after ignore", 2, 1'b0, 1'b0, -1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule